// File: doc/BRIEF.md
# Secondary Cache Burst Read Sequencer

This block drives an external synchronous second-level cache through a multi-quadword read. A requester hands it one of two request kinds: a refill of the first-level instruction cache after a miss, or the eviction of a modified block that must be copied out of the second-level cache. From the request kind and a configuration bit that selects 16-word or 32-word blocks, it picks a burst of 4 or 8 quadwords. It then drives one block-aligned quadword address per cycle to the data array. Alongside the first two addresses it reads the tag array, first in the requested way and then in the other way.

Each quadword comes back on a 128-bit bus with 10 check bits a fixed number of cycles after its address. The block registers it and streams it out with a one-cycle valid pulse, an index, and a marker on the final beat. The two tag words are presented the same way, with a flag that tells the requested way from the other one. Chip-select and output-enable strobes are active low. They are asserted only while an address or a returning word is in flight. The write enables stay high throughout.

The controller has three states. IDLE waits for a request. IDLE goes to ISSUE when a request is present. ISSUE drives one address per cycle and goes to DRAIN after the final index. DRAIN waits for the returns and goes back to IDLE after the cycle that presents the final quadword.

Top module: `sc_burst_reader`

## Requirements
- R1: A refill request (`req_wback`=0) always reads exactly 4 quadwords, whatever the value of `cfg_blk32`.
- R2: A write-back request (`req_wback`=1) reads 4 quadwords when `cfg_blk32`=0 and 8 quadwords when `cfg_blk32`=1.
- R3: The address sequence starts with the request address with its low 2 bits cleared (4-quadword burst) or its low 3 bits cleared (8-quadword burst). The address then rises by one per cycle. For a request accepted in cycle a, address k is on `sc_addr` in cycle a+2+k, and `sc_dway` equals the requested way.
- R4: The quadword for address k appears with `out_valid`=1 for one cycle, in cycle a+5+k, that is 3 cycles after its address. It carries the data and check bits sampled from the array, with `out_idx`=k and `out_last`=1 only for the final index.
- R5: `sc_tway` equals the requested way in cycle a+2 and the other way in cycle a+3. The tag words come out with `tag_valid`=1 in cycle a+5 (`tag_alt`=0) and in cycle a+6 (`tag_alt`=1).
- R6: `sc_dcs_n` and `sc_doe_n` are low from cycle a+2 through cycle a+3+N, where N is the burst length, and high in all other cycles.
- R7: `sc_tcs_n` and `sc_toe_n` are low from cycle a+2 through cycle a+5 and high in all other cycles.
- R8: `sc_dwe_n` and `sc_twe_n` stay high in every cycle.
- R9: `busy` is high from cycle a+1 through the cycle that shows `out_last`, and low afterwards. A request is accepted only while `busy` is low, so requests raised during a burst change neither the burst nor what follows it.
- R10: During and right after reset, `busy`, `out_valid` and `tag_valid` are low, and all chip-select strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; taken only when idle |
| req_wback | input | 1 | 1 = dirty-block write-back, 0 = instruction refill |
| req_addr | input | 19 | Quadword address of the request |
| req_way | input | 1 | Way holding the block |
| cfg_blk32 | input | 1 | 1 = 32-word blocks, 0 = 16-word blocks |
| busy | output | 1 | Sequence in progress |
| sc_addr | output | 19 | Cache array address |
| sc_dway | output | 1 | Data array way select |
| sc_dcs_n | output | 1 | Data array chip select, active low |
| sc_doe_n | output | 1 | Data array output enable, active low |
| sc_dwe_n | output | 1 | Data array write enable, active low |
| sc_data_in | input | 128 | Quadword read from the data array |
| sc_dchk_in | input | 10 | Check bits of the quadword |
| sc_tway | output | 1 | Tag array way select |
| sc_tcs_n | output | 1 | Tag array chip select, active low |
| sc_toe_n | output | 1 | Tag array output enable, active low |
| sc_twe_n | output | 1 | Tag array write enable, active low |
| sc_tag_in | input | 26 | Tag word read from the tag array |
| sc_tchk_in | input | 7 | Check bits of the tag |
| out_valid | output | 1 | Quadword output valid, one cycle each |
| out_last | output | 1 | Final quadword of the burst |
| out_idx | output | 3 | Index of the quadword within the burst |
| out_data | output | 128 | Quadword data |
| out_chk | output | 10 | Quadword check bits |
| tag_valid | output | 1 | Tag output valid |
| tag_alt | output | 1 | 0 = requested way, 1 = other way |
| tag_data | output | 26 | Tag word |
| tag_chk | output | 7 | Tag check bits |

## Verification
The assertions check on every cycle that consecutive issued addresses step by one, that `busy` holds until the last quadword appears and drops right after it, that every delivered quadword was read while the data chip select was low, and that the second tag word directly follows the first. Only the bench scenarios can show the exact cycle placement of the addresses, strobes and outputs relative to acceptance, the burst length chosen for each request kind and block size, the alignment of the starting address, and that requests raised while busy are dropped. The bench sweeps both request kinds, both block sizes, both ways and several addresses, and compares every output cycle against values computed from the request.

// File: rtl/sc_burst_pkg.sv
package sc_burst_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_DRAIN = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sc_burst_ctrl.sv
module sc_burst_ctrl
    import sc_burst_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int SHORT_QW  = 4,
    parameter int LONG_QW   = 8,
    parameter int TAG_READS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_wback,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_way,
    input  logic                       cfg_long,
    input  logic                       burst_done,
    output logic                       busy,
    output logic                       issue,
    output logic                       issue_last,
    output logic [$clog2(LONG_QW)-1:0] issue_idx,
    output logic                       issue_tag,
    output logic                       tag_alt,
    output logic [ADDR_W-1:0]          addr_q,
    output logic                       dway_q,
    output logic                       tway_q
);

    localparam int CNT_W = $clog2(LONG_QW);
    localparam logic [ADDR_W-1:0] SHORT_MASK = ~ADDR_W'(SHORT_QW - 1);
    localparam logic [ADDR_W-1:0] LONG_MASK  = ~ADDR_W'(LONG_QW - 1);
    localparam logic [CNT_W-1:0]  SHORT_LAST = CNT_W'(SHORT_QW - 1);
    localparam logic [CNT_W-1:0]  LONG_LAST  = CNT_W'(LONG_QW - 1);
    localparam logic [CNT_W-1:0]  TAG_LIMIT  = CNT_W'(TAG_READS);

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic [ADDR_W-1:0] base_q;
    logic              way_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_idx_q;
    logic              issued_q;
    logic              take_long;
    logic              accept;

    assign take_long = req_wback && cfg_long;
    assign accept    = (state_q == S_IDLE) && req_valid;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid)            state_d = S_ISSUE;
            S_ISSUE: if (cnt_q == last_idx_q)  state_d = S_DRAIN;
            S_DRAIN: if (burst_done)           state_d = S_IDLE;
            default:                           state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // per-state outputs
    always_comb begin
        issue      = 1'b0;
        issue_last = 1'b0;
        issue_tag  = 1'b0;
        tag_alt    = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            S_IDLE: begin
                busy = 1'b0;
            end
            S_ISSUE: begin
                issue      = 1'b1;
                issue_last = (cnt_q == last_idx_q);
                issue_tag  = (cnt_q < TAG_LIMIT);
                tag_alt    = (cnt_q != '0);
            end
            S_DRAIN: begin
                busy = 1'b1;
            end
            default: begin
                busy = 1'b1;
            end
        endcase
    end

    assign issue_idx = cnt_q;

    // burst bookkeeping and registered array address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q     <= '0;
            way_q      <= 1'b0;
            cnt_q      <= '0;
            last_idx_q <= '0;
            addr_q     <= '0;
            dway_q     <= 1'b0;
            tway_q     <= 1'b0;
            issued_q   <= 1'b0;
        end else begin
            issued_q <= issue;
            if (accept) begin
                base_q     <= req_addr & (take_long ? LONG_MASK : SHORT_MASK);
                way_q      <= req_way;
                last_idx_q <= take_long ? LONG_LAST : SHORT_LAST;
                cnt_q      <= '0;
            end else if (issue) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (issue) begin
                addr_q <= base_q | ADDR_W'(cnt_q);
                dway_q <= way_q;
            end
            if (issue_tag) begin
                tway_q <= way_q ^ tag_alt;
            end
        end
    end

    // R3: back-to-back issued addresses step by one
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (issued_q && $past(issued_q)) |-> (addr_q == $past(addr_q) + ADDR_W'(1)));

endmodule

// File: rtl/sc_return_pipe.sv
module sc_return_pipe #(
    parameter int LAT = 2,
    parameter int PW  = 138,
    parameter int MW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [MW-1:0] issue_meta,
    input  logic [PW-1:0] rd_payload,
    output logic          inflight,
    output logic          cap_v,
    output logic [MW-1:0] cap_meta,
    output logic [PW-1:0] cap_payload
);

    logic [LAT:0]  v_q;
    logic [MW-1:0] m_q [LAT+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q[0] <= 1'b0;
            m_q[0] <= '0;
        end else begin
            v_q[0] <= issue;
            m_q[0] <= issue_meta;
        end
    end

    for (genvar g = 1; g <= LAT; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q[g] <= 1'b0;
                m_q[g] <= '0;
            end else begin
                v_q[g] <= v_q[g-1];
                m_q[g] <= m_q[g-1];
            end
        end
    end

    assign inflight = |v_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_v       <= 1'b0;
            cap_meta    <= '0;
            cap_payload <= '0;
        end else begin
            cap_v <= v_q[LAT];
            if (v_q[LAT]) begin
                cap_meta    <= m_q[LAT];
                cap_payload <= rd_payload;
            end
        end
    end

endmodule

// File: rtl/sc_burst_reader.sv
module sc_burst_reader #(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 128,
    parameter int DCHK_W    = 10,
    parameter int TAG_W     = 26,
    parameter int TCHK_W    = 7,
    parameter int SHORT_QW  = 4,
    parameter int LONG_QW   = 8,
    parameter int RD_LAT    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_wback,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_way,
    input  logic                       cfg_blk32,
    output logic                       busy,
    output logic [ADDR_W-1:0]          sc_addr,
    output logic                       sc_dway,
    output logic                       sc_dcs_n,
    output logic                       sc_doe_n,
    output logic                       sc_dwe_n,
    input  logic [DATA_W-1:0]          sc_data_in,
    input  logic [DCHK_W-1:0]          sc_dchk_in,
    output logic                       sc_tway,
    output logic                       sc_tcs_n,
    output logic                       sc_toe_n,
    output logic                       sc_twe_n,
    input  logic [TAG_W-1:0]           sc_tag_in,
    input  logic [TCHK_W-1:0]          sc_tchk_in,
    output logic                       out_valid,
    output logic                       out_last,
    output logic [$clog2(LONG_QW)-1:0] out_idx,
    output logic [DATA_W-1:0]          out_data,
    output logic [DCHK_W-1:0]          out_chk,
    output logic                       tag_valid,
    output logic                       tag_alt,
    output logic [TAG_W-1:0]           tag_data,
    output logic [TCHK_W-1:0]          tag_chk
);

    localparam int IDX_W   = $clog2(LONG_QW);
    localparam int DMETA_W = IDX_W + 1;
    localparam int DPAY_W  = DATA_W + DCHK_W;
    localparam int TPAY_W  = TAG_W + TCHK_W;

    logic             issue;
    logic             issue_last;
    logic [IDX_W-1:0] issue_idx;
    logic             issue_tag;
    logic             issue_alt;
    logic             burst_done;
    logic             data_inflight;
    logic             tag_inflight;
    logic [DMETA_W-1:0] dmeta;
    logic [DPAY_W-1:0]  dpay;
    logic [TPAY_W-1:0]  tpay;

    sc_burst_ctrl #(
        .ADDR_W    (ADDR_W),
        .SHORT_QW  (SHORT_QW),
        .LONG_QW   (LONG_QW),
        .TAG_READS (2)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_wback  (req_wback),
        .req_addr   (req_addr),
        .req_way    (req_way),
        .cfg_long   (cfg_blk32),
        .burst_done (burst_done),
        .busy       (busy),
        .issue      (issue),
        .issue_last (issue_last),
        .issue_idx  (issue_idx),
        .issue_tag  (issue_tag),
        .tag_alt    (issue_alt),
        .addr_q     (sc_addr),
        .dway_q     (sc_dway),
        .tway_q     (sc_tway)
    );

    sc_return_pipe #(
        .LAT (RD_LAT),
        .PW  (DPAY_W),
        .MW  (DMETA_W)
    ) u_data_ret (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue),
        .issue_meta  ({issue_last, issue_idx}),
        .rd_payload  ({sc_data_in, sc_dchk_in}),
        .inflight    (data_inflight),
        .cap_v       (out_valid),
        .cap_meta    (dmeta),
        .cap_payload (dpay)
    );

    sc_return_pipe #(
        .LAT (RD_LAT),
        .PW  (TPAY_W),
        .MW  (1)
    ) u_tag_ret (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue_tag),
        .issue_meta  (issue_alt),
        .rd_payload  ({sc_tag_in, sc_tchk_in}),
        .inflight    (tag_inflight),
        .cap_v       (tag_valid),
        .cap_meta    (tag_alt),
        .cap_payload (tpay)
    );

    assign out_last   = dmeta[IDX_W];
    assign out_idx    = dmeta[IDX_W-1:0];
    assign out_data   = dpay[DPAY_W-1:DCHK_W];
    assign out_chk    = dpay[DCHK_W-1:0];
    assign tag_data   = tpay[TPAY_W-1:TCHK_W];
    assign tag_chk    = tpay[TCHK_W-1:0];
    assign burst_done = out_valid && out_last;

    assign sc_dcs_n = ~data_inflight;
    assign sc_doe_n = ~data_inflight;
    assign sc_tcs_n = ~tag_inflight;
    assign sc_toe_n = ~tag_inflight;
    assign sc_dwe_n = 1'b1;
    assign sc_twe_n = 1'b1;

    // R9: busy holds until the final quadword is delivered
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(out_valid && out_last)) |=> busy);

    // R4: the final quadword ends the sequence on the next cycle
    a_r4_last_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> !busy);

    // R6: a delivered quadword was read under an active data chip select
    a_r6_cs_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(!sc_dcs_n));

    // R5: the other-way tag immediately follows the requested-way tag
    a_r5_alt_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_valid && tag_alt) |-> $past(tag_valid && !tag_alt));

endmodule

// File: tb/tb_sc_burst_reader.sv
module tb_sc_burst_reader;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_wback = 1'b0;
    logic [18:0]  req_addr = '0;
    logic         req_way = 1'b0;
    logic         cfg_blk32 = 1'b0;
    logic         busy;
    logic [18:0]  sc_addr;
    logic         sc_dway, sc_dcs_n, sc_doe_n, sc_dwe_n;
    logic [127:0] sc_data_in = '0;
    logic [9:0]   sc_dchk_in = '0;
    logic         sc_tway, sc_tcs_n, sc_toe_n, sc_twe_n;
    logic [25:0]  sc_tag_in = '0;
    logic [6:0]   sc_tchk_in = '0;
    logic         out_valid, out_last;
    logic [2:0]   out_idx;
    logic [127:0] out_data;
    logic [9:0]   out_chk;
    logic         tag_valid, tag_alt;
    logic [25:0]  tag_data;
    logic [6:0]   tag_chk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sc_burst_reader dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wback(req_wback),
        .req_addr(req_addr), .req_way(req_way), .cfg_blk32(cfg_blk32), .busy(busy),
        .sc_addr(sc_addr), .sc_dway(sc_dway), .sc_dcs_n(sc_dcs_n), .sc_doe_n(sc_doe_n),
        .sc_dwe_n(sc_dwe_n), .sc_data_in(sc_data_in), .sc_dchk_in(sc_dchk_in),
        .sc_tway(sc_tway), .sc_tcs_n(sc_tcs_n), .sc_toe_n(sc_toe_n), .sc_twe_n(sc_twe_n),
        .sc_tag_in(sc_tag_in), .sc_tchk_in(sc_tchk_in), .out_valid(out_valid),
        .out_last(out_last), .out_idx(out_idx), .out_data(out_data), .out_chk(out_chk),
        .tag_valid(tag_valid), .tag_alt(tag_alt), .tag_data(tag_data), .tag_chk(tag_chk)
    );

    function automatic logic [127:0] fd(input logic [18:0] a, input logic w);
        fd = {4{w, 11'h5C3, ~w, a}};
    endfunction
    function automatic logic [9:0] fdc(input logic [18:0] a, input logic w);
        fdc = a[9:0] ^ {10{w}};
    endfunction
    function automatic logic [25:0] ft(input logic [18:0] a, input logic w);
        ft = {w, 6'h2B, a};
    endfunction
    function automatic logic [6:0] ftc(input logic [18:0] a, input logic w);
        ftc = a[6:0] ^ {7{w}};
    endfunction

    // array model: returns data two cycles after address, when selected
    initial begin
        logic [18:0] da1 = '0, da2 = '0, ta1 = '0, ta2 = '0;
        logic        dw1 = 0, dw2 = 0, dv1 = 0, dv2 = 0;
        logic        tw1 = 0, tw2 = 0, tv1 = 0, tv2 = 0;
        forever begin
            @(negedge clk);
            sc_data_in = dv2 ? fd(da2, dw2)  : '0;
            sc_dchk_in = dv2 ? fdc(da2, dw2) : '0;
            sc_tag_in  = tv2 ? ft(ta2, tw2)  : '0;
            sc_tchk_in = tv2 ? ftc(ta2, tw2) : '0;
            da2 = da1; dw2 = dw1; dv2 = dv1;
            ta2 = ta1; tw2 = tw1; tv2 = tv1;
            da1 = sc_addr; dw1 = sc_dway; dv1 = (sc_dcs_n === 1'b0);
            ta1 = sc_addr; tw1 = sc_tway; tv1 = (sc_tcs_n === 1'b0);
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic run_burst(input logic wb, input logic lng, input logic [18:0] a,
                             input logic w, input bit noise);
        int          n;
        logic [18:0] base;
        n    = (wb && lng) ? 8 : 4;
        base = a & ~19'(n - 1);
        @(negedge clk);
        req_valid = 1'b1; req_wback = wb; req_addr = a; req_way = w; cfg_blk32 = lng;
        chk(busy == 1'b0, "R9 idle before request", 128'(busy), 128'(0));
        for (int t = 1; t <= n + 6; t++) begin
            @(negedge clk);
            if (t == 1) begin
                req_valid = noise; req_wback = ~wb; req_addr = ~a; req_way = ~w;
            end
            if (t == 2 + n) req_valid = 1'b0;
            chk(busy == (t >= 1 && t <= 4 + n), "R9 busy window", 128'(busy),
                128'(t >= 1 && t <= 4 + n));
            chk(sc_dcs_n == !(t >= 2 && t <= 3 + n), "R6 data cs", 128'(sc_dcs_n),
                128'(!(t >= 2 && t <= 3 + n)));
            chk(sc_doe_n == !(t >= 2 && t <= 3 + n), "R6 data oe", 128'(sc_doe_n),
                128'(!(t >= 2 && t <= 3 + n)));
            chk(sc_tcs_n == !(t >= 2 && t <= 5), "R7 tag cs", 128'(sc_tcs_n),
                128'(!(t >= 2 && t <= 5)));
            chk(sc_toe_n == !(t >= 2 && t <= 5), "R7 tag oe", 128'(sc_toe_n),
                128'(!(t >= 2 && t <= 5)));
            chk(sc_dwe_n && sc_twe_n, "R8 write enables", 128'({sc_dwe_n, sc_twe_n}),
                128'(3));
            if (t >= 2 && t <= 1 + n) begin
                chk(sc_addr == (base | 19'(t - 2)), "R3 address", 128'(sc_addr),
                    128'(base | 19'(t - 2)));
                chk(sc_dway == w, "R3 data way", 128'(sc_dway), 128'(w));
            end
            if (t == 2) chk(sc_tway == w,  "R5 tag way first",  128'(sc_tway), 128'(w));
            if (t == 3) chk(sc_tway == ~w, "R5 tag way second", 128'(sc_tway), 128'(~w));
            chk(out_valid == (t >= 5 && t <= 4 + n), (wb ? "R2 beat count" : "R1 beat count"),
                128'(out_valid), 128'(t >= 5 && t <= 4 + n));
            if (t >= 5 && t <= 4 + n) begin
                chk(out_data == fd(base | 19'(t - 5), w), "R4 data", out_data,
                    fd(base | 19'(t - 5), w));
                chk(out_chk == fdc(base | 19'(t - 5), w), "R4 check bits", 128'(out_chk),
                    128'(fdc(base | 19'(t - 5), w)));
                chk(out_idx == 3'(t - 5), "R4 index", 128'(out_idx), 128'(t - 5));
                chk(out_last == (t == 4 + n), "R4 last", 128'(out_last), 128'(t == 4 + n));
            end
            chk(tag_valid == (t == 5 || t == 6), "R5 tag valid", 128'(tag_valid),
                128'(t == 5 || t == 6));
            if (t == 5) begin
                chk(tag_alt == 1'b0, "R5 first alt", 128'(tag_alt), 128'(0));
                chk(tag_data == ft(base, w) && tag_chk == ftc(base, w), "R5 first tag",
                    128'({tag_data, tag_chk}), 128'({ft(base, w), ftc(base, w)}));
            end
            if (t == 6) begin
                chk(tag_alt == 1'b1, "R5 second alt", 128'(tag_alt), 128'(1));
                chk(tag_data == ft(base | 19'd1, ~w) && tag_chk == ftc(base | 19'd1, ~w),
                    "R5 second tag", 128'({tag_data, tag_chk}),
                    128'({ft(base | 19'd1, ~w), ftc(base | 19'd1, ~w)}));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!busy && !out_valid && !tag_valid, "R10 reset outputs",
            128'({busy, out_valid, tag_valid}), 128'(0));
        chk(sc_dcs_n && sc_tcs_n, "R10 reset strobes", 128'({sc_dcs_n, sc_tcs_n}), 128'(3));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && sc_dcs_n && sc_tcs_n, "R10 after reset",
            128'({busy, sc_dcs_n, sc_tcs_n}), 128'(3));
        for (int k = 0; k < 2; k++)
            for (int l = 0; l < 2; l++)
                for (int w = 0; w < 2; w++)
                    for (int ai = 0; ai < 3; ai++)
                        run_burst(k[0], l[0], 19'h7ABCD ^ 19'(ai * 19'h15F3F), w[0], ai == 1);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule